// File: doc/BRIEF.md
# Serial NOR Flash Program and Erase Sequencer

This block carries out one complete write-type operation on a single-lane serial NOR flash. The host hands over an operation code, a 24-bit byte address and, for a page program, a byte count. The block then drives the flash pins by itself. It sends a one-byte write-enable frame, then the command frame with its address and any program data, and then status-read frames until the device reports that it is idle. The block contains its own byte shifter, which runs SPI mode 0.

Requests enter through a valid/ready handshake. The block accepts a request only while it is idle. Program data arrives as a valid/ready byte stream while the command frame is open. The block raises `wdat_ready` only when its shifter is free, so it takes at most one byte per serial byte time. The host may hold `wdat_valid` low for any number of cycles. While it waits, chip select stays low and the serial clock stays parked low. The host sees `busy` from acceptance until a one-cycle `done` pulse. At the pulse, two error flags give the outcome.

Top module: `nor_write_mgr`

## Requirements
- R1: After reset the block shows cs_n=1, sclk=0, busy=0, done=0, req_ready=1 and wdat_ready=0.
- R2: The serial clock is low whenever chip select is high. mosi changes only while sclk is low, and the flash samples it on the rising edge. Bytes go most significant bit first, and every frame holds a whole number of bytes.
- R3: Each accepted operation that is not rejected begins with a frame that holds only the byte 06h.
- R4: The second frame starts with the opcode for req_op: 0→02h (page program), 1→20h, 2→52h, 3→D8h, 4→C7h. Every opcode except C7h is followed by the three address bytes, high byte first. C7h carries no address.
- R5: For a page program, the command frame goes on to carry exactly req_len data bytes, in stream order. A byte is taken only in a cycle where wdat_valid and wdat_ready are both high, and a source that stalls loses no bytes.
- R6: A request is rejected in these cases: req_op is above 4, or it is a program with req_len=0, or a program where (req_addr[7:0] + req_len) exceeds 256. A rejected request gives done with err_reject=1. No frame goes on the bus and no data byte is taken. A program that ends exactly on a page boundary is accepted.
- R7: Chip select stays high for at least one serial clock period (2×SCK_HALF system cycles) between the frames of one operation.
- R8: After the command frame, each status poll is a two-byte frame: 05h followed by a dummy byte. During the dummy byte the block reads the status, and only status bit 0 (1 = still busy) decides the result. Polling repeats while that bit is 1, and a read with the bit at 0 ends the operation with no error flags.
- R9: poll_limit is sampled at acceptance. When that many status reads have all returned busy (a limit of 0 behaves as 1), the operation ends with done and err_timeout=1.
- R10: busy rises in the cycle after a request is accepted and stays high until the cycle after the single-cycle done pulse. req_ready is high exactly when busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 3 | 0 program, 1/2/3 erase of increasing size, 4 whole chip |
| req_addr | input | 24 | Start byte address |
| req_len | input | 9 | Program byte count, 1 to 256 |
| poll_limit | input | 16 | Maximum number of status reads |
| wdat_valid | input | 1 | Program data byte valid |
| wdat_ready | output | 1 | Block takes the byte on this edge when valid |
| wdat_byte | input | 8 | Program data byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_reject | output | 1 | Request refused (valid with done) |
| err_timeout | output | 1 | Poll limit reached (valid with done) |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Flash chip select, active low |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The in-line assertions check the pin discipline on every cycle. They check that the clock is parked while chip select is high, that mosi holds steady through each high clock phase, and that deselect lasts at least two cycles. They also check that done is a lone pulse that ends busy, that data is offered only inside a frame, and that a rejected request never lowers chip select. Other behaviour shows only in the bench's scenarios, where a behavioural flash model decodes the frames. That covers the frame contents and their order, the address byte order, the chip-erase form without an address, and data integrity under a stalling source. It also covers the page-boundary accept/reject edge, the exact number of polls before success or timeout, and the treatment of a poll limit of 0.

// File: rtl/nor_wr_pkg.sv
`timescale 1ns/1ps
package nor_wr_pkg;
  typedef enum logic [2:0] {
    OP_PROG       = 3'd0,
    OP_ERASE_SECT = 3'd1,
    OP_ERASE_HALF = 3'd2,
    OP_ERASE_BLK  = 3'd3,
    OP_ERASE_CHIP = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WEN, ST_GAP, ST_CMD, ST_DATA, ST_POLL, ST_FIN
  } seq_e;

  localparam logic [7:0] CMD_WEN  = 8'h06;
  localparam logic [7:0] CMD_STAT = 8'h05;
  localparam logic [7:0] CMD_FILL = 8'h00;

  function automatic logic [7:0] op_code(input op_e op);
    case (op)
      OP_PROG:       return 8'h02;
      OP_ERASE_SECT: return 8'h20;
      OP_ERASE_HALF: return 8'h52;
      OP_ERASE_BLK:  return 8'hD8;
      default:       return 8'hC7;
    endcase
  endfunction

  function automatic logic in_frame(input seq_e s);
    return (s == ST_WEN) || (s == ST_CMD) || (s == ST_DATA) || (s == ST_POLL);
  endfunction
endpackage

// File: rtl/nor_spi_shifter.sv
`timescale 1ns/1ps
// One-byte SPI mode-0 shifter: MSB first, changes mosi after falling edges,
// samples miso on rising edges and keeps only the most recent sampled bit.
module nor_spi_shifter #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       rx_last,
  output logic       done,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic          active;
  logic [DW-1:0] dcnt;
  logic [2:0]    bcnt;
  logic [7:0]    tsh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      dcnt    <= '0;
      bcnt    <= '0;
      tsh     <= '0;
      sclk    <= 1'b0;
      rx_last <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active <= 1'b1;
        tsh    <= tx_byte;
        dcnt   <= '0;
        bcnt   <= '0;
        sclk   <= 1'b0;
      end else if (active) begin
        if (dcnt == DW'(SCK_HALF - 1)) begin
          dcnt <= '0;
          sclk <= !sclk;
          if (!sclk) begin
            rx_last <= miso;
          end else if (bcnt == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bcnt <= bcnt + 3'd1;
            tsh  <= {tsh[6:0], 1'b0};
          end
        end else begin
          dcnt <= dcnt + DW'(1);
        end
      end
    end
  end

  assign mosi = tsh[7];

  assert_mosi_held_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  assert_byte_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/nor_wr_seq.sv
`timescale 1ns/1ps
module nor_wr_seq
  import nor_wr_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_W     = 16,
  parameter int ADDR_BYTES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [2:0]                    req_op,
  input  logic [8*ADDR_BYTES-1:0]       req_addr,
  input  logic [$clog2(PAGE_BYTES):0]   req_len,
  input  logic [POLL_W-1:0]             poll_limit,
  input  logic                          wdat_valid,
  output logic                          wdat_ready,
  input  logic [7:0]                    wdat_byte,
  output logic                          busy,
  output logic                          done,
  output logic                          err_reject,
  output logic                          err_timeout,
  output logic                          cs_n,
  output logic                          eng_start,
  output logic [7:0]                    eng_tx,
  input  logic                          eng_rx_bit,
  input  logic                          eng_done
);
  localparam int PW      = $clog2(PAGE_BYTES);
  localparam int LW      = PW + 1;
  localparam int AW      = 8 * ADDR_BYTES;
  localparam int GAP_CYC = 2 * SCK_HALF;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam int IW      = $clog2(ADDR_BYTES + 1);

  seq_e              st, st_nx, after_q;
  op_e               op_q;
  logic [AW-1:0]     addr_q;
  logic [LW-1:0]     len_q, dcount;
  logic [POLL_W-1:0] lim_q, polls;
  logic [GW-1:0]     gcnt;
  logic [IW-1:0]     idx;
  logic              inflight;

  logic          accept, reject_c, last_cmd, last_data, limit_hit;
  logic [LW:0]   span;

  assign accept    = req_valid && (st == ST_IDLE);
  assign span      = (LW+1)'(req_addr[PW-1:0]) + (LW+1)'(req_len);
  assign reject_c  = (req_op > 3'(OP_ERASE_CHIP)) ||
                     ((req_op == 3'(OP_PROG)) &&
                      ((req_len == '0) || (span > (LW+1)'(PAGE_BYTES))));
  assign last_cmd  = ((idx == '0) && (op_q == OP_ERASE_CHIP)) || (idx == IW'(ADDR_BYTES));
  assign last_data = (dcount == len_q - LW'(1));
  assign limit_hit = ({1'b0, polls} + (POLL_W+1)'(1)) >= {1'b0, lim_q};

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (accept) st_nx = reject_c ? ST_FIN : ST_WEN;
      ST_WEN:  if (eng_done) st_nx = ST_GAP;
      ST_GAP:  if (gcnt == GW'(GAP_CYC - 1)) st_nx = after_q;
      ST_CMD:  if (eng_done && last_cmd) st_nx = (op_q == OP_PROG) ? ST_DATA : ST_GAP;
      ST_DATA: if (eng_done && last_data) st_nx = ST_GAP;
      ST_POLL: if (eng_done && (idx == IW'(1)))
                 st_nx = (!eng_rx_bit || limit_hit) ? ST_FIN : ST_GAP;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    eng_start  = 1'b0;
    eng_tx     = CMD_FILL;
    wdat_ready = 1'b0;
    if (!inflight) begin
      case (st)
        ST_WEN: begin eng_start = 1'b1; eng_tx = CMD_WEN; end
        ST_CMD: begin
          eng_start = 1'b1;
          eng_tx = (idx == '0) ? op_code(op_q)
                               : 8'(addr_q >> (8 * (ADDR_BYTES - int'(idx))));
        end
        ST_DATA: begin wdat_ready = 1'b1; eng_start = wdat_valid; eng_tx = wdat_byte; end
        ST_POLL: begin eng_start = 1'b1; eng_tx = (idx == '0) ? CMD_STAT : CMD_FILL; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE; after_q <= ST_CMD; op_q <= OP_PROG; addr_q <= '0;
      len_q <= '0; dcount <= '0; lim_q <= '0; polls <= '0; gcnt <= '0;
      idx <= '0; inflight <= 1'b0; cs_n <= 1'b1;
      err_reject <= 1'b0; err_timeout <= 1'b0;
    end else begin
      st   <= st_nx;
      cs_n <= !in_frame(st_nx);
      if (eng_start) inflight <= 1'b1;
      else if (eng_done) inflight <= 1'b0;
      if (accept) begin
        op_q <= op_e'(req_op); addr_q <= req_addr; len_q <= req_len; lim_q <= poll_limit;
        idx <= '0; dcount <= '0; polls <= '0;
        err_reject <= reject_c; err_timeout <= 1'b0;
      end
      if (st_nx == ST_GAP && st != ST_GAP) begin
        gcnt    <= '0;
        after_q <= (st == ST_WEN) ? ST_CMD : ST_POLL;
      end else if (st == ST_GAP) begin
        gcnt <= gcnt + GW'(1);
      end
      if (st == ST_GAP && st_nx != ST_GAP) idx <= '0;
      else if (eng_done && (st == ST_CMD || st == ST_POLL)) idx <= idx + IW'(1);
      if (eng_done && st == ST_DATA) dcount <= dcount + LW'(1);
      if (eng_done && st == ST_POLL && idx == IW'(1)) begin
        polls <= polls + POLL_W'(1);
        if (eng_rx_bit && limit_hit) err_timeout <= 1'b1;
      end
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = (st == ST_FIN);
  assign req_ready = (st == ST_IDLE);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_ends_at_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  assert_data_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_ready |-> !cs_n);
  assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_reject) |-> (cs_n && $past(cs_n)));
  assert_deselect_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
endmodule

// File: rtl/nor_write_mgr.sv
`timescale 1ns/1ps
module nor_write_mgr #(
  parameter int SCK_HALF   = 2,
  parameter int PAGE_BYTES = 256,
  parameter int POLL_W     = 16,
  parameter int ADDR_BYTES = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [2:0]                  req_op,
  input  logic [8*ADDR_BYTES-1:0]     req_addr,
  input  logic [$clog2(PAGE_BYTES):0] req_len,
  input  logic [POLL_W-1:0]           poll_limit,
  input  logic                        wdat_valid,
  output logic                        wdat_ready,
  input  logic [7:0]                  wdat_byte,
  output logic                        busy,
  output logic                        done,
  output logic                        err_reject,
  output logic                        err_timeout,
  output logic                        sclk,
  output logic                        cs_n,
  output logic                        mosi,
  input  logic                        miso
);
  logic       eng_start, eng_done, eng_rx_bit;
  logic [7:0] eng_tx;

  nor_wr_seq #(
    .SCK_HALF(SCK_HALF), .PAGE_BYTES(PAGE_BYTES),
    .POLL_W(POLL_W), .ADDR_BYTES(ADDR_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .poll_limit(poll_limit),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_byte(wdat_byte),
    .busy(busy), .done(done), .err_reject(err_reject), .err_timeout(err_timeout),
    .cs_n(cs_n), .eng_start(eng_start), .eng_tx(eng_tx),
    .eng_rx_bit(eng_rx_bit), .eng_done(eng_done)
  );

  nor_spi_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
    .rx_last(eng_rx_bit), .done(eng_done),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assert_sclk_parked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
endmodule

// File: tb/nor_write_mgr_tb.sv
`timescale 1ns/1ps
module nor_write_mgr_tb;
  localparam int HALF = 2;
  localparam int GAP  = 2 * HALF;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = !clk;

  logic req_valid = 0, wdat_valid = 0, miso = 0;
  logic [2:0] req_op = 0;
  logic [23:0] req_addr = 0;
  logic [8:0] req_len = 0;
  logic [15:0] poll_limit = 0;
  logic [7:0] wdat_byte = 0;
  logic req_ready, wdat_ready, busy, done, err_reject, err_timeout, sclk, cs_n, mosi;

  nor_write_mgr #(.SCK_HALF(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .poll_limit(poll_limit),
    .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_byte(wdat_byte),
    .busy(busy), .done(done), .err_reject(err_reject), .err_timeout(err_timeout),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // behavioural flash: frame log and status responder
  logic [7:0] sh = 0;
  int nb = 0, busy_left = 0;
  bit inf = 0;
  logic [7:0] cur[$];
  int flen_q[$];
  logic [7:0] fbyte_q[$];

  always @(negedge cs_n) if (rst_n) begin inf = 1; nb = 0; cur.delete(); miso = 0; end
  always @(posedge sclk) if (!cs_n) begin
    sh = {sh[6:0], mosi}; nb++;
    if (nb % 8 == 0) cur.push_back(sh);
  end
  always @(negedge sclk) if (!cs_n) begin
    logic [7:0] stat;
    stat = {7'h55, busy_left > 0};
    if (nb >= 8 && nb < 16 && cur[0] == 8'h05) miso = stat[15 - nb];
    else miso = 0;
  end
  always @(posedge cs_n) if (inf) begin
    inf = 0;
    chk(nb % 8 == 0, "R2", "whole bytes in frame", nb % 8, 0);
    flen_q.push_back(cur.size());
    foreach (cur[k]) fbyte_q.push_back(cur[k]);
    if (cur.size() == 2 && cur[0] == 8'h05 && busy_left > 0) busy_left--;
  end

  // per-clock reference: busy/ready model, clock parking, mosi hold, deselect gap
  bit run_chk = 0, bexp = 0, prev_acc = 0, prev_done = 0, had_frame = 0;
  logic prev_sclk = 0, prev_mosi = 0, prev_cs = 1;
  int gap = 0;
  always begin
    @(negedge clk); #2;
    if (rst_n && run_chk) begin
      bexp = prev_acc || (bexp && !prev_done);
      chk(busy == bexp, "R10", "busy vs model", busy, bexp);
      chk(req_ready == !bexp, "R10", "req_ready vs model", req_ready, !bexp);
      if (cs_n) chk(sclk == 0, "R2", "sclk parked while deselected", sclk, 0);
      if (sclk && prev_sclk) chk(mosi == prev_mosi, "R2", "mosi held in high phase", mosi, prev_mosi);
      if (cs_n) gap++;
      else begin
        if (prev_cs && had_frame) chk(gap >= GAP, "R7", "deselect cycles", gap, GAP);
        if (prev_cs) had_frame = 1;
        gap = 0;
      end
      prev_acc = req_valid && req_ready; prev_done = done;
      prev_sclk = sclk; prev_mosi = mosi; prev_cs = cs_n;
    end
  end

  function automatic logic [7:0] opc(input logic [2:0] op);
    case (op) 3'd0: return 8'h02; 3'd1: return 8'h20; 3'd2: return 8'h52;
      3'd3: return 8'hD8; default: return 8'hC7; endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [23:0] addr, input int len,
                        input int lim, input int bpolls, input bit exp_rej,
                        input bit exp_tmo, input bit stall);
    logic [7:0] dq[$];
    int elen[$];
    logic [7:0] eb[$];
    int i = 0, cyc = 0, xfer = 0, npoll, p;
    bit seen = 0, rj = 0, tm = 0;
    for (int k = 0; k < len; k++) dq.push_back(8'(addr[7:0] * 3 + k * 29 + 8'h5A));
    if (!exp_rej) begin
      elen.push_back(1); eb.push_back(8'h06);
      p = 1; eb.push_back(opc(op));
      if (op != 3'd4) begin eb.push_back(addr[23:16]); eb.push_back(addr[15:8]); eb.push_back(addr[7:0]); p += 3; end
      if (op == 3'd0) foreach (dq[k]) begin eb.push_back(dq[k]); p++; end
      elen.push_back(p);
      npoll = exp_tmo ? ((lim < 1) ? 1 : lim) : bpolls + 1;
      for (int k = 0; k < npoll; k++) begin elen.push_back(2); eb.push_back(8'h05); eb.push_back(8'h00); end
    end
    flen_q.delete(); fbyte_q.delete(); busy_left = bpolls; had_frame = 0;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = addr; req_len = 9'(len); poll_limit = 16'(lim);
    @(negedge clk);
    req_valid = 0;
    while (!seen && cyc < 20000) begin
      if (cyc > 0) @(negedge clk);
      wdat_valid = (i < len) && !(stall && ((cyc % 7) < 3));
      wdat_byte = (i < len) ? dq[i] : 8'h00;
      #2;
      if (done) begin seen = 1; rj = err_reject; tm = err_timeout; end
      if (wdat_valid && wdat_ready) begin i++; xfer++; end
      cyc++;
    end
    wdat_valid = 0;
    chk(seen, "R10", "done reached", seen, 1);
    chk(rj == exp_rej, "R6", "err_reject", rj, exp_rej);
    chk(tm == exp_tmo, "R9", "err_timeout", tm, exp_tmo);
    chk(xfer == (exp_rej ? 0 : (op == 3'd0 ? len : 0)), "R5", "bytes taken", xfer, exp_rej ? 0 : len);
    chk(flen_q.size() == elen.size(), exp_tmo ? "R9" : "R8", "frame count", flen_q.size(), elen.size());
    if (flen_q.size() == elen.size() && fbyte_q.size() == eb.size()) begin
      p = 0;
      foreach (elen[f]) begin
        chk(flen_q[f] == elen[f], "R4", "frame length", flen_q[f], elen[f]);
        for (int k = 0; k < elen[f]; k++) begin
          chk(fbyte_q[p] == eb[p], f == 0 ? "R3" : (f == 1 ? (k > 3 ? "R5" : "R4") : "R8"),
              "frame byte", fbyte_q[p], eb[p]);
          p++;
        end
      end
    end else if (flen_q.size() == elen.size())
      chk(0, "R4", "total bytes", fbyte_q.size(), eb.size());
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    #2;
    chk(cs_n == 1, "R1", "cs_n at reset", cs_n, 1);
    chk(sclk == 0, "R1", "sclk at reset", sclk, 0);
    chk(busy == 0 && done == 0, "R1", "busy/done at reset", {busy, done}, 0);
    chk(req_ready == 1 && wdat_ready == 0, "R1", "ready at reset", {req_ready, wdat_ready}, 2);
    run_chk = 1;
    run_op(3'd0, 24'h123400, 4, 10, 2, 0, 0, 1);    // program, stalling source
    run_op(3'd1, 24'hABCDEF, 0, 10, 0, 0, 0, 0);    // sector erase
    run_op(3'd2, 24'h010000, 0, 10, 1, 0, 0, 0);    // half-block erase
    run_op(3'd3, 24'hFF0000, 0, 10, 0, 0, 0, 0);    // block erase
    run_op(3'd4, 24'h777777, 0, 10, 3, 0, 0, 0);    // chip erase, no address
    run_op(3'd0, 24'h0000F0, 17, 10, 0, 1, 0, 0);   // R6 crosses page
    run_op(3'd0, 24'h000000, 0, 10, 0, 1, 0, 0);    // R6 zero length
    run_op(3'd5, 24'h000000, 0, 10, 0, 1, 0, 0);    // R6 unknown op
    run_op(3'd0, 24'h0000F0, 16, 10, 1, 0, 0, 1);   // R6 exact page end accepted
    run_op(3'd0, 24'h000100, 256, 10, 0, 0, 0, 0);  // full page
    run_op(3'd1, 24'h002000, 0, 3, 10, 0, 1, 0);    // R9 timeout after 3 reads
    run_op(3'd3, 24'h030000, 0, 0, 5, 0, 1, 0);     // R9 limit 0 acts as 1
    run_op(3'd1, 24'h040000, 0, 4, 3, 0, 0, 0);     // R8 success on last allowed read
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule